// File: doc/BRIEF.md
# USB Line-State Sampler with Clock Recovery

This block watches the two data wires of a low-speed or full-speed USB link. The wires are sampled by a clock much faster than the bit rate. Each sample of the (D+, D-) pair is sorted into one of four line states: J, K, single-ended zero or single-ended one. While the line rests in J, a change to K marks the start of a packet. From that edge the block places one sample point near the middle of every bit period. At each of those points it issues a strobe that carries the line state.

A bang-bang loop corrects the sample timing whenever the line changes between J and K from one sample point to the next. The line state seen at the expected bit boundary tells the loop whether the sample points run early or late. The loop then moves the next sample point a little and adjusts the tracked bit period a little. A single-ended zero ends the packet. When a J follows that zero, the block pulses end of packet, goes back to idle and reloads the nominal bit period. Decoding of the bit values, bit unstuffing and packet parsing are left to the blocks that follow.

The ratio of sample clocks to full-speed bits and the speed are parameters. At low speed the bit period is eight times the full-speed one.

Top module: `usb_line_sampler`

## Requirements
- R1: At full speed the synchronized pair (D+, D-) = (1,0) is reported as J (code 2'b01) and (0,1) as K (code 2'b10). (0,0) is single-ended zero (code 2'b00) and (1,1) is single-ended one (code 2'b11).
- R2: With LOW_SPEED set, (D+, D-) = (0,1) is J and (1,0) is K. Both-low and both-high keep their full-speed codes.
- R3: In idle, only a J followed by K in consecutive synchronized samples starts a packet. It gives exactly one one-cycle sopPulse. In idle no symbol strobe is issued, and a single-ended one glitch on an idle J line starts nothing.
- R4: The first symbol strobe follows sopPulse by half the nominal bit period plus one clock. During a run of equal symbols the strobes are one nominal bit period apart, and two strobes are never issued on consecutive clocks.
- R5: From start of packet until end of packet, one strobe is issued per bit. Its code equals the symbol driven for that bit, for any J/K pattern.
- R6: On a J/K change between sample points, the tracked period is shortened or lengthened by 1/1024 of itself, and the next sample point is moved by 1/128 of a bit toward the boundary it missed. This lets a packet whose bits run about 1.5% slower than nominal be sampled without error.
- R7: A single-ended zero sampled inside a packet enters the end state. The first J sampled right after a single-ended zero gives a one-cycle eopPulse, together with that J's strobe, and a return to idle.
- R8: A single-ended one sampled inside a packet is reported with its code and does not end the packet.
- R9: During and right after reset, symValid, sopPulse and eopPulse are low and the block is idle.
- R10: After end of packet the nominal period is restored, so a following packet is sampled with the nominal first-strobe delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low reset, forces idle |
| dpIn | input | 1 | Asynchronous D+ level |
| dmIn | input | 1 | Asynchronous D- level |
| symValid | output | 1 | One-cycle strobe per sampled bit |
| symCode | output | 2 | Line state at the strobe: 00 SE0, 01 J, 10 K, 11 SE1 |
| sopPulse | output | 1 | One-cycle start-of-packet pulse |
| eopPulse | output | 1 | One-cycle end-of-packet pulse |

## Verification
The bench builds two copies of the block. The full-speed copy runs at eight clocks per bit. Its short period makes fixed fractional corrections visible within a few dozen bits, so a mix of eight- and nine-clock bits shows whether the loop tracks a slow sender. The low-speed copy runs with two clocks per full-speed bit, which gives sixteen clocks per bit. That exercises the swapped J/K polarity and the eight-fold period scaling without long runs.

// File: rtl/usbls_pkg.sv
package usbls_pkg;
  localparam int FRAC_W = 8;

  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_J   = 2'b01,
    SYM_K   = 2'b10,
    SYM_SE1 = 2'b11
  } lineSym_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BITS = 2'b01,
    ST_EOP  = 2'b10
  } rxState_e;

  typedef struct packed {
    logic restart;
    logic advance;
    logic shorten;
    logic lengthen;
    logic restore;
  } timingCtl_t;
endpackage

// File: rtl/usbls_datapath.sv
module usbls_datapath
  import usbls_pkg::*;
#(
  parameter int CLK_PER_BIT = 8,
  parameter int LOW_SPEED   = 0,
  parameter int CNT_W       = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dpIn,
  input  logic       dmIn,
  input  timingCtl_t ctl,
  output lineSym_e   lineSym,
  output lineSym_e   prevSym,
  output logic       sampleHit,
  output lineSym_e   edgeSym
);
  localparam int BIT_CLKS = (LOW_SPEED != 0) ? CLK_PER_BIT * 8 : CLK_PER_BIT;
  localparam int POS_W = CNT_W + FRAC_W;
  localparam logic [POS_W-1:0] NOM_PER = POS_W'(BIT_CLKS) << FRAC_W;
  localparam logic [1:0] IDLE_PINS = (LOW_SPEED != 0) ? 2'b01 : 2'b10;

  logic [1:0] syncA, syncB;
  logic [CNT_W-1:0] cnt;
  logic [POS_W-1:0] pos, period, nextPos, nextPer, edgePos, perStep, phStep;
  logic edgeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= IDLE_PINS;
      syncB <= IDLE_PINS;
    end else begin
      syncA <= {dpIn, dmIn};
      syncB <= syncA;
    end
  end

  generate
    if (LOW_SPEED != 0) begin : g_low
      always_comb begin
        case (syncB)
          2'b00:   lineSym = SYM_SE0;
          2'b01:   lineSym = SYM_J;
          2'b10:   lineSym = SYM_K;
          default: lineSym = SYM_SE1;
        endcase
      end
    end else begin : g_full
      always_comb begin
        case (syncB)
          2'b00:   lineSym = SYM_SE0;
          2'b10:   lineSym = SYM_J;
          2'b01:   lineSym = SYM_K;
          default: lineSym = SYM_SE1;
        endcase
      end
    end
  endgenerate

  always_comb begin
    perStep = period >> 10;
    phStep  = period >> 7;
    nextPer = period;
    if (ctl.shorten)  nextPer = period - perStep;
    if (ctl.lengthen) nextPer = period + perStep;
    nextPos = pos + nextPer;
    if (ctl.shorten)  nextPos = pos + nextPer - phStep;
    if (ctl.lengthen) nextPos = pos + nextPer + phStep;
    edgePos = pos - (period >> 1);
  end

  assign sampleHit = (cnt == pos[POS_W-1:FRAC_W]);
  assign edgeHit   = (cnt == edgePos[POS_W-1:FRAC_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSym <= SYM_J;
      edgeSym <= SYM_J;
      cnt     <= '0;
      pos     <= NOM_PER >> 1;
      period  <= NOM_PER;
    end else begin
      prevSym <= lineSym;
      if (edgeHit) edgeSym <= lineSym;
      if (ctl.restart) begin
        cnt <= '0;
        pos <= NOM_PER >> 1;
      end else begin
        cnt <= cnt + 1'b1;
        if (ctl.advance) begin
          pos    <= nextPos;
          period <= nextPer;
        end
      end
      if (ctl.restore) period <= NOM_PER;
    end
  end

  assert_sample_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    sampleHit |=> !sampleHit);

  assert_restore_nominal_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restore |=> (period == NOM_PER));
endmodule

// File: rtl/usbls_control.sv
module usbls_control
  import usbls_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lineSym_e   lineSym,
  input  lineSym_e   prevSym,
  input  logic       sampleHit,
  input  lineSym_e   edgeSym,
  output timingCtl_t ctl,
  output logic       symValid,
  output lineSym_e   symCode,
  output logic       sopPulse,
  output logic       eopPulse
);
  rxState_e state, nextState;
  lineSym_e lastSym;
  logic lineJk, edgeJk, jkChange, active;

  assign lineJk   = (lineSym == SYM_J) || (lineSym == SYM_K);
  assign edgeJk   = (edgeSym == SYM_J) || (edgeSym == SYM_K);
  assign jkChange = lineJk && edgeJk && (lineSym != lastSym);
  assign active   = (state != ST_IDLE);

  always_comb begin
    ctl = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (prevSym == SYM_J && lineSym == SYM_K) begin
          ctl.restart = 1'b1;
          nextState = ST_BITS;
        end
      end
      ST_BITS: begin
        if (sampleHit) begin
          ctl.advance = 1'b1;
          if (jkChange) begin
            if (edgeSym == lineSym) ctl.shorten = 1'b1;
            else                    ctl.lengthen = 1'b1;
          end
          if (lineSym == SYM_SE0) nextState = ST_EOP;
        end
      end
      ST_EOP: begin
        if (sampleHit) begin
          ctl.advance = 1'b1;
          if (lineSym == SYM_J && lastSym == SYM_SE0) begin
            ctl.restore = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lastSym  <= SYM_J;
      symValid <= 1'b0;
      symCode  <= SYM_J;
      sopPulse <= 1'b0;
      eopPulse <= 1'b0;
    end else begin
      state    <= nextState;
      symValid <= sampleHit && active;
      if (sampleHit && active) symCode <= lineSym;
      sopPulse <= ctl.restart;
      eopPulse <= ctl.restore;
      if (ctl.restart) lastSym <= SYM_K;
      else if (sampleHit && active) lastSym <= lineSym;
    end
  end

  assert_sop_enters_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    sopPulse |-> (state == ST_BITS));

  assert_idle_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !eopPulse) |-> !symValid);

  assert_sop_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    sopPulse |=> !sopPulse);

  assert_eop_enters_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    eopPulse |-> (state == ST_IDLE));

  assert_eop_with_j_R7: assert property (@(posedge clk) disable iff (!rstN)
    eopPulse |-> (symValid && symCode == SYM_J));
endmodule

// File: rtl/usb_line_sampler.sv
module usb_line_sampler
  import usbls_pkg::*;
#(
  parameter int CLK_PER_BIT = 8,
  parameter int LOW_SPEED   = 0,
  parameter int CNT_W       = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dpIn,
  input  logic       dmIn,
  output logic       symValid,
  output logic [1:0] symCode,
  output logic       sopPulse,
  output logic       eopPulse
);
  timingCtl_t ctl;
  lineSym_e lineSym, prevSym, edgeSym, codeSym;
  logic sampleHit;

  usbls_datapath #(
    .CLK_PER_BIT(CLK_PER_BIT),
    .LOW_SPEED(LOW_SPEED),
    .CNT_W(CNT_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn), .ctl(ctl),
    .lineSym(lineSym), .prevSym(prevSym), .sampleHit(sampleHit), .edgeSym(edgeSym)
  );

  usbls_control u_control (
    .clk(clk), .rstN(rstN), .lineSym(lineSym), .prevSym(prevSym),
    .sampleHit(sampleHit), .edgeSym(edgeSym), .ctl(ctl),
    .symValid(symValid), .symCode(codeSym), .sopPulse(sopPulse), .eopPulse(eopPulse)
  );

  assign symCode = codeSym;
endmodule

// File: tb/usb_line_sampler_bench.sv
`timescale 1ns/1ps
module usb_line_sampler_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dpF = 1'b1, dmF = 1'b0;
  logic dpL = 1'b0, dmL = 1'b1;
  logic fValid, fSop, fEop, lValid, lSop, lEop;
  logic [1:0] fCode, lCode;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usb_line_sampler #(.CLK_PER_BIT(8), .LOW_SPEED(0), .CNT_W(16)) u_usb_line_sampler (
    .clk(clk), .rstN(rstN), .dpIn(dpF), .dmIn(dmF),
    .symValid(fValid), .symCode(fCode), .sopPulse(fSop), .eopPulse(fEop));

  usb_line_sampler #(.CLK_PER_BIT(2), .LOW_SPEED(1), .CNT_W(16)) u_usb_line_sampler_ls (
    .clk(clk), .rstN(rstN), .dpIn(dpL), .dmIn(dmL),
    .symValid(lValid), .symCode(lCode), .sopPulse(lSop), .eopPulse(lEop));

  logic [1:0] fSym [0:1023];
  int fCyc [0:1023];
  int fN = 0, fSopN = 0, fEopN = 0, fSopCyc = 0;
  logic [1:0] lSym [0:255];
  int lCyc [0:255];
  int lN = 0, lSopN = 0, lEopN = 0, lSopCyc = 0;

  always @(negedge clk) begin
    if (fValid && fN < 1024) begin fSym[fN] <= fCode; fCyc[fN] <= cyc; fN <= fN + 1; end
    if (fSop) begin fSopN <= fSopN + 1; fSopCyc <= cyc; end
    if (fEop) fEopN <= fEopN + 1;
    if (lValid && lN < 256) begin lSym[lN] <= lCode; lCyc[lN] <= cyc; lN <= lN + 1; end
    if (lSop) begin lSopN <= lSopN + 1; lSopCyc <= cyc; end
    if (lEop) lEopN <= lEopN + 1;
  end

  localparam int NVEC = 6;
  localparam logic [31:0] PAT [NVEC] = '{32'h0000_0055, 32'h0000_00FF, 32'h0000_00F1,
                                         32'h0000_A5C3, 32'h0000_0013, 32'h0000_8001};
  localparam int LEN [NVEC] = '{8, 8, 12, 16, 5, 16};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fDrive(input logic [1:0] s, input int n);
    case (s)
      2'd0: {dpF, dmF} = 2'b00;
      2'd1: {dpF, dmF} = 2'b10;
      2'd2: {dpF, dmF} = 2'b01;
      default: {dpF, dmF} = 2'b11;
    endcase
    repeat (n) @(negedge clk);
  endtask

  task automatic lDrive(input logic [1:0] s, input int n);
    case (s)
      2'd0: {dpL, dmL} = 2'b00;
      2'd1: {dpL, dmL} = 2'b01;
      2'd2: {dpL, dmL} = 2'b10;
      default: {dpL, dmL} = 2'b11;
    endcase
    repeat (n) @(negedge clk);
  endtask

  task automatic fPacket(input logic [31:0] pat, input int len, input int slowEvery);
    fDrive(2'd1, 24);
    for (int i = 0; i < len; i++)
      fDrive(pat[i] ? 2'd2 : 2'd1,
             (slowEvery != 0 && (i % slowEvery) == slowEvery - 1) ? 9 : 8);
    fDrive(2'd0, 8);
    fDrive(2'd0, 8);
    fDrive(2'd1, 8);
    fDrive(2'd1, 40);
  endtask

  task automatic fVerify(input int base, input int sop0, input int eop0,
                         input logic [31:0] pat, input int len, input string req);
    int bad, act, exp;
    bad = -1; act = 0; exp = 0;
    check(fN - base == len + 3, {req, " strobe count"}, fN - base, len + 3);
    for (int i = 0; i < len + 3; i++) begin
      int e;
      e = (i < len) ? (pat[i] ? 2 : 1) : ((i == len + 2) ? 1 : 0);
      if (bad < 0 && (base + i >= fN || int'(fSym[base + i]) != e)) begin
        bad = i; exp = e; act = (base + i < fN) ? int'(fSym[base + i]) : -1;
      end
    end
    check(bad < 0, {req, " symbol sequence"}, act, exp);
    check(fSopN - sop0 == 1, {req, " R3 sop count"}, fSopN - sop0, 1);
    check(fEopN - eop0 == 1, {req, " R7 eop count"}, fEopN - eop0, 1);
  endtask

  initial begin
    int base, s0, e0, seen;
    seen = 0;
    repeat (3) @(negedge clk);
    check(!fValid && !fSop && !fEop, "R9 outputs low in reset", {fValid, fSop, fEop}, 0);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (fValid || fSop || fEop || lValid || lSop || lEop) seen++;
    end
    check(seen == 0, "R9 quiet after reset", seen, 0);

    // R3: SE1 glitch on idle J starts nothing
    s0 = fSopN; base = fN;
    fDrive(2'd3, 8);
    fDrive(2'd1, 30);
    check(fSopN == s0 && fN == base, "R3 idle SE1 glitch ignored", fSopN - s0 + fN - base, 0);

    // Vector table: R1, R5, R7
    for (int v = 0; v < NVEC; v++) begin
      base = fN; s0 = fSopN; e0 = fEopN;
      fPacket(PAT[v], LEN[v], 0);
      fVerify(base, s0, e0, PAT[v], LEN[v], (v == 0) ? "R1 R5 alternating" : "R5 R7 pattern");
    end

    // R4 / R10: first-strobe delay and spacing on an all-K run after a prior packet
    base = fN; s0 = fSopN; e0 = fEopN;
    fPacket(32'h0000_00FF, 8, 0);
    check(fCyc[base] - fSopCyc == 5, "R4 R10 first strobe delay", fCyc[base] - fSopCyc, 5);
    seen = 0;
    for (int i = 1; i < 8; i++) if (fCyc[base + i] - fCyc[base + i - 1] != 8) seen++;
    check(seen == 0, "R4 strobe spacing in K run", seen, 0);

    // R8: SE1 inside a packet
    base = fN; s0 = fEopN;
    fDrive(2'd1, 24);
    fDrive(2'd2, 8); fDrive(2'd1, 8); fDrive(2'd3, 8); fDrive(2'd2, 8);
    fDrive(2'd0, 8); fDrive(2'd0, 8); fDrive(2'd1, 48);
    check(fN - base == 7, "R8 strobe count", fN - base, 7);
    check(fSym[base + 2] == 2'b11, "R8 SE1 code", fSym[base + 2], 3);
    check(fSym[base + 3] == 2'b10, "R8 packet continues with K", fSym[base + 3], 2);
    check(fEopN - s0 == 1, "R8 R7 single eop", fEopN - s0, 1);

    // R6: slow sender, one nine-clock bit in every eight
    base = fN; s0 = fSopN; e0 = fEopN;
    fPacket(32'hB5AD_3C95, 32, 8);
    fVerify(base, s0, e0, 32'hB5AD_3C95, 32, "R6 slow sender");

    // R2: low-speed copy, swapped polarity, 16 clocks per bit
    base = lN; s0 = lSopN; e0 = lEopN;
    lDrive(2'd1, 40);
    for (int i = 0; i < 6; i++) lDrive(((6'h35 >> i) & 1) != 0 ? 2'd2 : 2'd1, 16);
    lDrive(2'd0, 16); lDrive(2'd0, 16); lDrive(2'd1, 80);
    check(lN - base == 9, "R2 strobe count", lN - base, 9);
    seen = 0;
    for (int i = 0; i < 6; i++)
      if (int'(lSym[base + i]) != (((6'h35 >> i) & 1) != 0 ? 2 : 1)) seen++;
    check(seen == 0, "R2 swapped J/K codes", seen, 0);
    check(lCyc[base] - lSopCyc == 9, "R2 R4 low-speed first strobe delay", lCyc[base] - lSopCyc, 9);
    check(lEopN - e0 == 1 && lSopN - s0 == 1, "R2 R7 low-speed sop/eop", lEopN - e0, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule